// File: doc/BRIEF.md
# Debug Register Access Chain

This block is a test-access-port path that lets an external debugger read and write a 128-entry space of 32-bit registers over the four-wire boundary-scan port. A 4-bit instruction register picks one of four data paths: a device identity word, a one-bit pass-through, a 5-bit chain-select register, or a 40-bit access register. The access register reaches the register space only while the chain-select register holds chain 0.

Each access scan carries a 32-bit data field in bits 31:0, a 7-bit register address in bits 38:32 and a direction bit in bit 39, where 1 means write. Every field is shifted in least significant bit first. When the scan completes, the block issues a single-cycle strobe on a plain register bus, either a write or a read. A read result is latched and leaves the chip during the next access scan, so reads are pipelined by one scan. A debugger fetches the last result by following the read with a read of register 0. A bulk drain of a data port repeats reads of that port and addresses register 0 on the final scan, so the port is never popped one time too many. The register bus runs on the test clock.

Top module: `jtag_reg_access`

## Requirements
- R1: A synchronous reset (`rst` high at a rising `tck` edge), or five consecutive rising edges with `tms` high, puts the controller in its reset state. In that state the instruction is IDCODE (0xE) and the selected chain is 0, no bus strobe is active, and `tdo` is 0.
- R2: An instruction scan captures the pattern 0b0001 and shifts 4 bits in and out, least significant bit first. The new instruction takes effect at Update-IR.
- R3: With instruction 0xE, a data scan shifts out the 32-bit `IDCODE` parameter, least significant bit first.
- R4: Instruction 0xF, and every code other than 0x2, 0xC and 0xE, selects a 1-bit bypass path that captures 0. Each bit on `tdo` is the `tdi` bit from one shift earlier.
- R5: Instruction 0x2 selects a 5-bit chain-select register. Capture loads the chain currently selected, and Update-DR makes the shifted value the new chain.
- R6: With instruction 0xC and chain 0, an access scan with bit 39 = 1 writes. In the cycle after Update-DR, `reg_wr` is high for exactly one cycle, with `reg_addr` set to bits 38:32 and `reg_wdata` set to bits 31:0. Addresses 0 through 127 are all reachable.
- R7: An access scan with bit 39 = 0 on chain 0 reads. In the cycle after Update-DR, `reg_rd` is high for exactly one cycle with `reg_addr` set to bits 38:32, and `reg_rdata` is latched at the end of that cycle.
- R8: Capture of an access scan loads bits 31:0 with the data latched by the most recent read and loads bits 39:32 with 0. A write scan leaves the latched value unchanged.
- R9: While the selected chain is not 0, an access scan makes no bus cycle and leaves the latched read value unchanged.
- R10: `reg_wr` and `reg_rd` are never high in the same cycle.
- R11: A run of reads from a data port that pops on every read strobe returns each popped word exactly once, one scan later. Ending the run with a read of register 0 pops nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all logic and the register bus run on it |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid in the shift states |
| reg_addr | output | 7 | Register bus address |
| reg_wdata | output | 32 | Register bus write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 32 | Read data returned by the register file |

## Verification
On every cycle, the assertions check the bus-strobe rules. Strobes are single-cycle and never overlap. A strobe appears only right after an Update-DR, and only while chain 0 is selected. The assertions also check that both reset routes land the controller in its reset state. The pipelined read behaviour needs the bench's scenarios, because it spans several scans: data that appears one scan late, a write scan that leaves the latched word alone, and a drain of a popping port that ends on register 0. The bench's scenarios also cover the shift formats of each data path and the capture value of the chain-select register.

// File: rtl/jra_pkg.sv
package jra_pkg;
    localparam int IR_W    = 4;
    localparam int CHAIN_W = 5;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int ACC_W   = DATA_W + ADDR_W + 1;

    localparam logic [IR_W-1:0]    OP_CHAIN_SEL = 4'h2;
    localparam logic [IR_W-1:0]    OP_ACCESS    = 4'hC;
    localparam logic [IR_W-1:0]    OP_IDCODE    = 4'hE;
    localparam logic [IR_W-1:0]    IR_CAPTURE   = 4'b0001;
    localparam logic [CHAIN_W-1:0] BUS_CHAIN    = '0;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
        ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        PATH_BYPASS, PATH_IDCODE, PATH_CHAIN, PATH_ACCESS
    } dr_path_t;

    // Field order matches the serial word: bit 39 direction, 38:32 address, 31:0 data
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } acc_word_t;

    function automatic tap_state_t tap_next(tap_state_t s, logic tms);
        case (s)
            ST_TLR:    return tms ? ST_TLR    : ST_RTI;
            ST_RTI:    return tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: return tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: return tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: return tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: return tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: return tms ? ST_SEL_DR : ST_RTI;
            default:   return ST_TLR;
        endcase
    endfunction

    function automatic dr_path_t decode_op(logic [IR_W-1:0] op);
        case (op)
            OP_CHAIN_SEL: return PATH_CHAIN;
            OP_ACCESS:    return PATH_ACCESS;
            OP_IDCODE:    return PATH_IDCODE;
            default:      return PATH_BYPASS;
        endcase
    endfunction
endpackage

// File: rtl/jra_tap_ctrl.sv
module jra_tap_ctrl
    import jra_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_t state
);
    always_ff @(posedge tck) begin
        if (rst) state <= ST_TLR;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/jra_ir.sv
module jra_ir
    import jra_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_t state,
    input  logic       tdi,
    output logic       ir_lsb,
    output dr_path_t   path
);
    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_op;

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_sh <= '0;
            ir_op <= OP_IDCODE;
        end else begin
            case (state)
                ST_TLR:    ir_op <= OP_IDCODE;
                ST_CAP_IR: ir_sh <= IR_CAPTURE;
                ST_SHF_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                ST_UPD_IR: ir_op <= ir_sh;
                default: ;
            endcase
        end
    end

    assign ir_lsb = ir_sh[0];
    assign path   = decode_op(ir_op);
endmodule

// File: rtl/jra_dr.sv
module jra_dr
    import jra_pkg::*;
#(
    parameter logic [DATA_W-1:0] IDCODE = 32'h3C2D_E0A5
) (
    input  logic                tck,
    input  logic                rst,
    input  tap_state_t          state,
    input  logic                tdi,
    input  dr_path_t            path,
    input  logic [DATA_W-1:0]   rd_hold,
    output logic                dr_lsb,
    output logic [CHAIN_W-1:0]  cur_chain,
    output logic                acc_go,
    output acc_word_t           acc_req
);
    logic [ACC_W-1:0] dr_sh;

    always_ff @(posedge tck) begin
        if (rst) begin
            dr_sh     <= '0;
            cur_chain <= BUS_CHAIN;
        end else begin
            if (state == ST_TLR) cur_chain <= BUS_CHAIN;
            if (state == ST_CAP_DR) begin
                case (path)
                    PATH_IDCODE: dr_sh <= ACC_W'(IDCODE);
                    PATH_CHAIN:  dr_sh <= ACC_W'(cur_chain);
                    PATH_ACCESS: dr_sh <= ACC_W'(rd_hold);
                    default:     dr_sh <= '0;
                endcase
            end
            if (state == ST_SHF_DR) begin
                case (path)
                    PATH_IDCODE: dr_sh[DATA_W-1:0]  <= {tdi, dr_sh[DATA_W-1:1]};
                    PATH_CHAIN:  dr_sh[CHAIN_W-1:0] <= {tdi, dr_sh[CHAIN_W-1:1]};
                    PATH_ACCESS: dr_sh              <= {tdi, dr_sh[ACC_W-1:1]};
                    default:     dr_sh[0]           <= tdi;
                endcase
            end
            if (state == ST_UPD_DR && path == PATH_CHAIN)
                cur_chain <= dr_sh[CHAIN_W-1:0];
        end
    end

    assign dr_lsb  = dr_sh[0];
    assign acc_req = acc_word_t'(dr_sh);
    assign acc_go  = (state == ST_UPD_DR) && (path == PATH_ACCESS) && (cur_chain == BUS_CHAIN);
endmodule

// File: rtl/jra_bus_port.sv
module jra_bus_port
    import jra_pkg::*;
(
    input  logic              tck,
    input  logic              rst,
    input  logic              acc_go,
    input  acc_word_t         acc_req,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [DATA_W-1:0] rd_hold
);
    always_ff @(posedge tck) begin
        if (rst) begin
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            rd_hold   <= '0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (reg_rd) rd_hold <= reg_rdata;
            if (acc_go) begin
                reg_addr <= acc_req.addr;
                if (acc_req.wr) begin
                    reg_wr    <= 1'b1;
                    reg_wdata <= acc_req.data;
                end else begin
                    reg_rd <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/jtag_reg_access.sv
module jtag_reg_access
    import jra_pkg::*;
#(
    parameter logic [DATA_W-1:0] IDCODE = 32'h3C2D_E0A5
) (
    input  logic              tck,
    input  logic              rst,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    tap_state_t         tap_state;
    dr_path_t           path;
    logic               ir_lsb;
    logic               dr_lsb;
    logic               acc_go;
    acc_word_t          acc_req;
    logic [DATA_W-1:0]  rd_hold;
    logic [CHAIN_W-1:0] cur_chain;

    jra_tap_ctrl u_ctrl (
        .tck(tck), .rst(rst), .tms(tms), .state(tap_state)
    );

    jra_ir u_ir (
        .tck(tck), .rst(rst), .state(tap_state), .tdi(tdi), .ir_lsb(ir_lsb), .path(path)
    );

    jra_dr #(.IDCODE(IDCODE)) u_dr (
        .tck(tck), .rst(rst), .state(tap_state), .tdi(tdi), .path(path), .rd_hold(rd_hold),
        .dr_lsb(dr_lsb), .cur_chain(cur_chain), .acc_go(acc_go), .acc_req(acc_req)
    );

    jra_bus_port u_bus (
        .tck(tck), .rst(rst), .acc_go(acc_go), .acc_req(acc_req), .reg_rdata(reg_rdata),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .rd_hold(rd_hold)
    );

    always_comb begin
        case (tap_state)
            ST_SHF_DR: tdo = dr_lsb;
            ST_SHF_IR: tdo = ir_lsb;
            default:   tdo = 1'b0;
        endcase
    end
endmodule

// File: rtl/jra_checker.sv
module jra_checker
    import jra_pkg::*;
(
    input logic               tck,
    input logic               rst,
    input logic               tms,
    input tap_state_t         tap_state,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [CHAIN_W-1:0] cur_chain
);
    a_r10_one_strobe: assert property (@(posedge tck) disable iff (rst)
        !(reg_wr && reg_rd));

    a_r6_wr_single: assert property (@(posedge tck) disable iff (rst)
        reg_wr |=> !reg_wr);

    a_r7_rd_single: assert property (@(posedge tck) disable iff (rst)
        reg_rd |=> !reg_rd);

    a_r6_strobe_after_update: assert property (@(posedge tck) disable iff (rst)
        (reg_wr || reg_rd) |-> $past(tap_state) == ST_UPD_DR);

    a_r9_bus_chain_only: assert property (@(posedge tck) disable iff (rst)
        (reg_wr || reg_rd) |-> cur_chain == BUS_CHAIN);

    a_r1_sync_reset: assert property (@(posedge tck)
        $past(rst) |-> (tap_state == ST_TLR && !reg_wr && !reg_rd));

    a_r1_tms_reset: assert property (@(posedge tck) disable iff (rst)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> tap_state == ST_TLR);
endmodule

bind jtag_reg_access jra_checker u_chk (
    .tck(tck), .rst(rst), .tms(tms), .tap_state(tap_state),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .cur_chain(cur_chain)
);

// File: tb/jtag_reg_access_test.sv
`timescale 1ns/1ps
module jtag_reg_access_test;
    localparam logic [31:0] IDC    = 32'h3C2D_E0A5;
    localparam logic [31:0] ID_REG = 32'h4E7B_0001;
    localparam logic [31:0] POP_BASE = 32'hA000_0000;

    logic        tck = 1'b0;
    logic        rst = 1'b1;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo;
    logic [6:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_wr;
    logic        reg_rd;
    logic [31:0] reg_rdata;

    jtag_reg_access #(.IDCODE(IDC)) uut (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata)
    );

    always #2 tck = ~tck;

    int nchk = 0;
    int nfail = 0;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // register file model: address 0 is identification, address 4 pops a data port
    logic [31:0] rf [128];
    int pop_n = 0;
    initial for (int i = 0; i < 128; i++) rf[i] = 32'h0;
    assign reg_rdata = (reg_addr == 7'd0) ? ID_REG :
                       (reg_addr == 7'd4) ? POP_BASE + 32'(pop_n) : rf[reg_addr];
    always @(posedge tck) begin
        if (reg_wr) rf[reg_addr] <= reg_wdata;
        if (reg_rd && reg_addr == 7'd4) pop_n <= pop_n + 1;
    end

    // scoreboard queues
    typedef struct {
        logic        wr;
        logic [6:0]  addr;
        logic [31:0] data;
        string       tag;
    } bus_t;
    typedef struct {
        logic [39:0] val;
        string       tag;
    } scan_t;
    bus_t        bus_q[$];
    scan_t       exp_q[$];
    logic [39:0] got_q[$];

    // bench-side model
    logic [31:0] mdl [128];
    logic [31:0] exp_hold = 32'h0;
    int          mdl_pop = 0;
    int          chain_m = 0;
    initial for (int i = 0; i < 128; i++) mdl[i] = 32'h0;

    always @(negedge tck) begin : monitor
        bus_t  eb;
        scan_t es;
        logic [39:0] g;
        if (!rst && (reg_wr || reg_rd)) begin
            check("R10 single strobe", {63'h0, reg_wr & reg_rd}, 64'h0);
            if (bus_q.size() == 0) begin
                nchk++;
                nfail++;
                $display("FAIL R9: actual bus cycle wr=%0b addr=%h expected none", reg_wr, reg_addr);
            end else begin
                eb = bus_q.pop_front();
                check(eb.tag, {23'h0, reg_wr, reg_rd, reg_addr, (reg_wr ? reg_wdata : 32'h0)},
                      {23'h0, eb.wr, !eb.wr, eb.addr, (eb.wr ? eb.data : 32'h0)});
            end
        end
        if (got_q.size() > 0 && exp_q.size() > 0) begin
            g  = got_q.pop_front();
            es = exp_q.pop_front();
            check(es.tag, {24'h0, g}, {24'h0, es.val});
        end
    end

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck);
        tms = m;
        tdi = d;
        o   = tdo;
        @(posedge tck);
    endtask

    task automatic ir_scan(input logic [3:0] op, output logic [3:0] cap);
        logic b;
        step(1, 0, b); step(1, 0, b); step(0, 0, b); step(0, 0, b);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, op[i], b);
            cap[i] = b;
        end
        step(1, 0, b); step(0, 0, b);
    endtask

    task automatic dr_scan(input int n, input logic [39:0] din, output logic [39:0] dout);
        logic b;
        dout = '0;
        step(1, 0, b); step(0, 0, b); step(0, 0, b);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], b);
            dout[i] = b;
        end
        step(1, 0, b); step(0, 0, b); step(0, 0, b);
    endtask

    task automatic load_ir(input logic [3:0] op);
        logic [3:0] c;
        ir_scan(op, c);
        check("R2 IR capture", {60'h0, c}, 64'h1);
    endtask

    task automatic acc(input logic wr, input logic [6:0] a, input logic [31:0] d, input string tag);
        logic [39:0] o;
        scan_t s;
        bus_t bi;
        s.val = {8'h0, exp_hold};
        s.tag = tag;
        exp_q.push_back(s);
        if (chain_m == 0) begin
            bi.wr = wr; bi.addr = a; bi.data = d; bi.tag = tag;
            bus_q.push_back(bi);
            if (wr) mdl[a] = d;
            else if (a == 7'd0) exp_hold = ID_REG;
            else if (a == 7'd4) begin
                exp_hold = POP_BASE + 32'(mdl_pop);
                mdl_pop++;
            end else exp_hold = mdl[a];
        end
        dr_scan(40, {wr, a, d}, o);
        got_q.push_back(o);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge tck);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual run still busy expected finished");
        summary();
        $finish;
    end

    initial begin : main
        logic [39:0] o;
        logic b;
        repeat (3) @(posedge tck);
        @(negedge tck);
        check("R1 reset bus idle", {62'h0, reg_wr, reg_rd}, 64'h0);
        check("R1 reset tdo", {63'h0, tdo}, 64'h0);
        rst = 1'b0;
        tms = 1'b0;
        @(posedge tck);
        @(posedge tck);

        // R1/R3: identity after reset without loading IR
        dr_scan(32, 40'h0, o);
        check("R1 default IDCODE", {24'h0, o}, {32'h0, IDC});
        load_ir(4'hE);
        dr_scan(32, 40'h0, o);
        check("R3 IDCODE", {24'h0, o}, {32'h0, IDC});

        // R4 bypass, explicit and unknown code
        load_ir(4'hF);
        dr_scan(8, 40'hB6, o);
        check("R4 bypass", {24'h0, o}, {56'h0, 8'hB6 << 1} & 64'hFF);
        load_ir(4'h5);
        dr_scan(8, 40'h5D, o);
        check("R4 unknown code bypass", {24'h0, o}, {56'h0, 8'h5D << 1} & 64'hFF);

        // R5 chain select
        load_ir(4'h2);
        dr_scan(5, 40'h3, o);
        check("R5 chain capture initial", {24'h0, o}, 64'h0);
        dr_scan(5, 40'h0, o);
        check("R5 chain capture after update", {24'h0, o}, 64'h3);
        dr_scan(5, 40'h3, o);
        chain_m = 3;

        // R9 accesses on another chain
        load_ir(4'hC);
        acc(1'b1, 7'd9, 32'h1111_2222, "R9 write on chain 3");
        acc(1'b0, 7'd9, 32'h0, "R9 read on chain 3");
        load_ir(4'h2);
        dr_scan(5, 40'h0, o);
        check("R5 chain readback", {24'h0, o}, 64'h3);
        chain_m = 0;
        load_ir(4'hC);

        // R6 writes, boundary addresses
        acc(1'b1, 7'd9,   32'hDEAD_0009, "R6 write addr 9");
        acc(1'b1, 7'd127, 32'hC0DE_007F, "R6 write addr 127");
        acc(1'b1, 7'd1,   32'h0000_0101, "R6 write addr 1");
        // R7/R8 pipelined reads
        acc(1'b0, 7'd9,   32'h0, "R7 read addr 9");
        acc(1'b0, 7'd127, 32'h0, "R8 returns addr 9");
        acc(1'b1, 7'd2,   32'h2222_0002, "R8 write keeps hold");
        acc(1'b0, 7'd1,   32'h0, "R8 hold after write");
        acc(1'b0, 7'd0,   32'h0, "R8 fetch via reg 0");
        acc(1'b0, 7'd2,   32'h0, "R8 identification returned");
        acc(1'b1, 7'd9,   32'h9999_AAAA, "R6 overwrite addr 9");
        acc(1'b0, 7'd9,   32'h0, "R7 read after overwrite");
        acc(1'b0, 7'd0,   32'h0, "R8 overwritten value");

        // R11 bulk drain of the popping port
        for (int i = 0; i < 5; i++) acc(1'b0, 7'd4, 32'h0, "R11 bulk read");
        acc(1'b0, 7'd0, 32'h0, "R11 last pop via reg 0");
        acc(1'b0, 7'd0, 32'h0, "R11 identification after drain");
        repeat (2) @(posedge tck);
        check("R11 pop count", 64'(pop_n), 64'd5);

        // R1 reset by TMS
        load_ir(4'h2);
        dr_scan(5, 40'h7, o);
        for (int i = 0; i < 5; i++) step(1, 0, b);
        step(0, 0, b);
        dr_scan(32, 40'h0, o);
        check("R1 TMS reset IDCODE", {24'h0, o}, {32'h0, IDC});
        load_ir(4'h2);
        dr_scan(5, 40'h0, o);
        check("R1 TMS reset chain", {24'h0, o}, 64'h0);

        // R1 synchronous reset mid-run
        load_ir(4'hF);
        @(negedge tck); rst = 1'b1;
        repeat (2) @(posedge tck);
        @(negedge tck);
        check("R1 reset mid-run strobes", {62'h0, reg_wr, reg_rd}, 64'h0);
        rst = 1'b0;
        tms = 1'b0;
        @(posedge tck);
        dr_scan(32, 40'h0, o);
        check("R1 reset restores IDCODE", {24'h0, o}, {32'h0, IDC});

        repeat (4) @(posedge tck);
        check("R9 no leftover bus items", 64'(bus_q.size()), 64'd0);
        check("R8 no leftover scan items", 64'(exp_q.size() + got_q.size()), 64'd0);
        summary();
        $finish;
    end
endmodule